// File: doc/BRIEF.md
# Configuration Start-up Sequencer

This block closes out device configuration. While configuration is still running it pulls the open-drain completion pin low. Once the configuration engine reports that it has finished, the block lets go of the pin. The pin then reads high only through a pull-up: the internal one, which an option bit switches on, or an external one.

The block senses the pin level through a two-flop synchronizer. Each start-up clock edge that sees the pin high then advances a short chain of sticky stages. Option bits pick which stage ends the global output 3-state and which stage ends the global set/reset. A fixed stage raises a completion flag, which downstream logic uses to enable boundary scan and readback and to control the internal oscillator.

The start-up clock is either the configuration clock or a user clock, chosen by an option bit. If that clock stops, every stage keeps its state. The user may also drive the global 3-state and the global set/reset from two inputs of the design. Each input has its own enable and polarity option, and when enabled it can hold its global signal asserted on top of the sequencer.

Top module: `startup_seq`

## Requirements
- R1: While `rst` is high on a start-up clock edge, and after that edge, `done_drive_low`=1, `gts`=1, `gsr`=1 and `finished`=0, provided both user gating inputs are disabled.
- R2: `done_drive_low` stays 1 until a start-up clock edge samples `cfg_complete`=1. From that edge on it is 0, and it stays 0 until reset, even if `cfg_complete` falls again.
- R3: `pullup_en` equals `opt_pullup`. The sequence starts only from the synchronized `done_pad_in`. Stage 1 of the chain is set by the third start-up clock edge that samples `done_pad_in`=1, and stage n by edge n+2. While the pin reads low, no stage is set.
- R4: `gts` goes to 0 once the stage picked by `opt_io_tap` is set (code 0..3 selects stage 1..4; code 0 is the default use).
- R5: `gsr` goes to 0 once the stage picked by `opt_rst_tap` is set (same code; code 1, stage 2, is the default use).
- R6: `finished` goes to 1 once stage 3 is set, and stays 1 until reset.
- R7: With `clk_sel`=0 the sequence runs on `cfg_clk`. With `clk_sel`=1 it runs on `usr_clk`, and `cfg_clk` then has no effect.
- R8: If the selected start-up clock stops part-way, `gts`, `gsr`, `finished` and `done_drive_low` all keep their values for as long as it is stopped.
- R9: When `gts_en`=1, `gts` is 1 whenever `usr_gts` XOR `gts_inv` is 1. When `gts_en`=0, `usr_gts` and `gts_inv` have no effect on `gts`.
- R10: When `gsr_en`=1, `gsr` is 1 whenever `usr_gsr` XOR `gsr_inv` is 1. When `gsr_en`=0, `usr_gsr` and `gsr_inv` have no effect on `gsr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock |
| usr_clk | input | 1 | User-supplied start-up clock |
| rst | input | 1 | Synchronous active-high reset, sampled on the selected clock |
| clk_sel | input | 1 | Start-up clock source: 0 = cfg_clk, 1 = usr_clk |
| cfg_complete | input | 1 | Configuration engine has finished loading |
| done_pad_in | input | 1 | Sensed level of the completion pin |
| opt_pullup | input | 1 | Option: enable internal pull-up on the completion pin |
| opt_io_tap | input | 2 | Option: stage that ends global 3-state (0..3 = stage 1..4) |
| opt_rst_tap | input | 2 | Option: stage that ends global set/reset (0..3 = stage 1..4) |
| usr_gts | input | 1 | User global 3-state request |
| gts_en | input | 1 | Enable for usr_gts |
| gts_inv | input | 1 | Invert usr_gts |
| usr_gsr | input | 1 | User global set/reset request |
| gsr_en | input | 1 | Enable for usr_gsr |
| gsr_inv | input | 1 | Invert usr_gsr |
| done_drive_low | output | 1 | 1 = pull the completion pin low, 0 = release it |
| pullup_en | output | 1 | Internal pull-up enable for the completion pin |
| gts | output | 1 | Global 3-state of all user outputs, active high |
| gsr | output | 1 | Global set/reset of all flip-flops, active high |
| finished | output | 1 | Start-up complete; enables scan/readback and oscillator control |

## Verification
The assertions assume three things about the inputs. `rst` and all option bits are stable around edges of the selected start-up clock. `clk_sel` changes only while the block is held in reset. `done_pad_in` comes from the block's own pin drive combined with a pull-up, so it cannot read high while the block pulls the pin low. The bench builds the pin from `done_drive_low`, `pullup_en` and an optional external pull-up. It changes the clock source and the option bits only under reset, and it changes the user gating inputs half a cycle away from the active edge. When it stops the user clock, it does so in its low phase, so that no half edge reaches the block.

// File: rtl/startup_pkg.sv
package startup_pkg;

    // Default number of sticky stages in the start-up chain
    localparam int unsigned DEF_CHAIN_LEN = 4;
    // Default synchronizer depth for the sensed completion pin
    localparam int unsigned DEF_SYNC_STAGES = 2;
    // Default stage (1-based) that raises the completion flag
    localparam int unsigned DEF_FINISH_STAGE = 3;

    typedef enum logic {
        SRC_CFG_CLK  = 1'b0,
        SRC_USER_CLK = 1'b1
    } clk_src_e;

    // Per global signal: user gating options
    typedef struct packed {
        logic enable;
        logic invert;
    } user_gate_t;

    // User request after enable and polarity are applied
    function automatic logic user_request(input user_gate_t opt, input logic level);
        return opt.enable & (level ^ opt.invert);
    endfunction

endpackage

// File: rtl/startup_done_ctl.sv
module startup_done_ctl #(
    parameter int unsigned SYNC_STAGES = startup_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_complete,
    input  logic done_pad_in,
    output logic done_drive_low,
    output logic done_seen
);

    logic                   released;
    logic [SYNC_STAGES-1:0] sync_q;

    // Sticky release of the completion pin
    always_ff @(posedge clk) begin
        if (rst) begin
            released <= 1'b0;
        end else if (cfg_complete) begin
            released <= 1'b1;
        end
    end

    // Synchronizer for the sensed pin level
    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= done_pad_in;
            end
        end else begin : g_sync_many
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], done_pad_in};
            end
        end
    endgenerate

    assign done_drive_low = ~released;
    assign done_seen      = sync_q[SYNC_STAGES-1];

    // R2
    pin_release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(done_drive_low) |-> !done_drive_low);

    // R2
    pin_release_on_complete_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_complete |=> !done_drive_low);

endmodule

// File: rtl/startup_chain.sv
module startup_chain #(
    parameter int unsigned CHAIN_LEN = startup_pkg::DEF_CHAIN_LEN
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 advance,
    output logic [CHAIN_LEN-1:0] stage
);

    generate
        for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
            logic feed;
            if (i == 0) begin : g_head
                assign feed = advance;
            end else begin : g_body
                assign feed = stage[i-1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    stage[i] <= 1'b0;
                end else if (feed) begin
                    stage[i] <= 1'b1;
                end
            end

            // R3
            stage_order_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(stage[i]) |-> $past(feed));
        end
    endgenerate

endmodule

// File: rtl/startup_release.sv
module startup_release #(
    parameter int unsigned CHAIN_LEN = startup_pkg::DEF_CHAIN_LEN,
    parameter int unsigned TAP_W     = $clog2(CHAIN_LEN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CHAIN_LEN-1:0]    stage,
    input  logic [TAP_W-1:0]        tap,
    input  startup_pkg::user_gate_t gate_opt,
    input  logic                    user_level,
    output logic                    active
);
    import startup_pkg::*;

    logic seq_hold;
    logic user_hold;

    assign seq_hold  = ~stage[tap];
    assign user_hold = user_request(gate_opt, user_level);
    assign active    = seq_hold | user_hold;

    // R9 R10
    user_gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_opt.enable && (user_level != gate_opt.invert)) |-> active);

    // R4 R5
    release_needs_stage_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> stage[tap]);

endmodule

// File: rtl/startup_seq.sv
module startup_seq #(
    parameter int unsigned CHAIN_LEN    = startup_pkg::DEF_CHAIN_LEN,
    parameter int unsigned SYNC_STAGES  = startup_pkg::DEF_SYNC_STAGES,
    parameter int unsigned FINISH_STAGE = startup_pkg::DEF_FINISH_STAGE,
    parameter int unsigned TAP_W        = $clog2(CHAIN_LEN)
) (
    input  logic             cfg_clk,
    input  logic             usr_clk,
    input  logic             rst,
    input  logic             clk_sel,
    input  logic             cfg_complete,
    input  logic             done_pad_in,
    input  logic             opt_pullup,
    input  logic [TAP_W-1:0] opt_io_tap,
    input  logic [TAP_W-1:0] opt_rst_tap,
    input  logic             usr_gts,
    input  logic             gts_en,
    input  logic             gts_inv,
    input  logic             usr_gsr,
    input  logic             gsr_en,
    input  logic             gsr_inv,
    output logic             done_drive_low,
    output logic             pullup_en,
    output logic             gts,
    output logic             gsr,
    output logic             finished
);
    import startup_pkg::*;

    logic                 seq_clk;
    logic                 done_seen;
    logic [CHAIN_LEN-1:0] stage;
    user_gate_t           gts_opt;
    user_gate_t           gsr_opt;

    // Start-up clock source
    assign seq_clk = (clk_src_e'(clk_sel) == SRC_USER_CLK) ? usr_clk : cfg_clk;

    assign pullup_en = opt_pullup;
    assign gts_opt   = '{enable: gts_en, invert: gts_inv};
    assign gsr_opt   = '{enable: gsr_en, invert: gsr_inv};

    startup_done_ctl #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_done (
        .clk            (seq_clk),
        .rst            (rst),
        .cfg_complete   (cfg_complete),
        .done_pad_in    (done_pad_in),
        .done_drive_low (done_drive_low),
        .done_seen      (done_seen)
    );

    startup_chain #(
        .CHAIN_LEN (CHAIN_LEN)
    ) u_chain (
        .clk     (seq_clk),
        .rst     (rst),
        .advance (done_seen),
        .stage   (stage)
    );

    startup_release #(
        .CHAIN_LEN (CHAIN_LEN),
        .TAP_W     (TAP_W)
    ) u_gts (
        .clk        (seq_clk),
        .rst        (rst),
        .stage      (stage),
        .tap        (opt_io_tap),
        .gate_opt   (gts_opt),
        .user_level (usr_gts),
        .active     (gts)
    );

    startup_release #(
        .CHAIN_LEN (CHAIN_LEN),
        .TAP_W     (TAP_W)
    ) u_gsr (
        .clk        (seq_clk),
        .rst        (rst),
        .stage      (stage),
        .tap        (opt_rst_tap),
        .gate_opt   (gsr_opt),
        .user_level (usr_gsr),
        .active     (gsr)
    );

    assign finished = stage[FINISH_STAGE-1];

    // R6
    finished_sticky_chk: assert property (@(posedge seq_clk) disable iff (rst)
        $past(finished) |-> finished);

    // R6
    finished_needs_release_chk: assert property (@(posedge seq_clk) disable iff (rst)
        finished |-> !done_drive_low);

endmodule

// File: tb/tb_startup_seq.sv
`timescale 1ns/1ps
module tb_startup_seq;

    logic       cfg_clk = 1'b0;
    logic       usr_clk = 1'b0;
    logic       usr_run = 1'b1;
    logic       rst = 1'b1;
    logic       clk_sel = 1'b0;
    logic       cfg_complete = 1'b0;
    logic       opt_pullup = 1'b1;
    logic       ext_pullup = 1'b0;
    logic [1:0] opt_io_tap = 2'd0;
    logic [1:0] opt_rst_tap = 2'd1;
    logic       usr_gts = 1'b0, gts_en = 1'b0, gts_inv = 1'b0;
    logic       usr_gsr = 1'b0, gsr_en = 1'b0, gsr_inv = 1'b0;
    logic       done_drive_low, pullup_en, gts, gsr, finished;
    logic       done_pad_in;
    logic       bseq;

    int    errors = 0;
    int    checks = 0;
    bit    chk_on = 1'b0;
    string cur_req = "R1";

    // Reference state
    int m_cnt = 0;
    bit m_rel = 1'b0;

    always #2.5 cfg_clk = ~cfg_clk;
    always begin
        #6;
        if (usr_run) usr_clk = ~usr_clk;
    end

    // Pin: open drain with internal or external pull-up
    assign done_pad_in = !done_drive_low && (pullup_en || ext_pullup);
    assign bseq = clk_sel ? usr_clk : cfg_clk;

    startup_seq dut (
        .cfg_clk(cfg_clk), .usr_clk(usr_clk), .rst(rst), .clk_sel(clk_sel),
        .cfg_complete(cfg_complete), .done_pad_in(done_pad_in), .opt_pullup(opt_pullup),
        .opt_io_tap(opt_io_tap), .opt_rst_tap(opt_rst_tap),
        .usr_gts(usr_gts), .gts_en(gts_en), .gts_inv(gts_inv),
        .usr_gsr(usr_gsr), .gsr_en(gsr_en), .gsr_inv(gsr_inv),
        .done_drive_low(done_drive_low), .pullup_en(pullup_en),
        .gts(gts), .gsr(gsr), .finished(finished)
    );

    // Behavioural model: count edges that see the pin high
    always @(posedge bseq) begin
        if (rst) begin
            m_cnt = 0;
            m_rel = 1'b0;
        end else begin
            if (done_pad_in) m_cnt = m_cnt + 1;
            if (cfg_complete) m_rel = 1'b1;
        end
    end

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL [%s] %s actual=%0b expected=%0b at %0t", cur_req, tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic e_gts, e_gsr, e_fin;
        e_gts = !(m_cnt >= int'(opt_io_tap) + 3) || (gts_en && (usr_gts ^ gts_inv));
        e_gsr = !(m_cnt >= int'(opt_rst_tap) + 3) || (gsr_en && (usr_gsr ^ gsr_inv));
        e_fin = (m_cnt >= 5);
        check1("R2 done_drive_low", done_drive_low, !m_rel);
        check1("R3 pullup_en", pullup_en, opt_pullup);
        check1("R4 gts", gts, e_gts);
        check1("R5 gsr", gsr, e_gsr);
        check1("R6 finished", finished, e_fin);
    endtask

    always @(negedge bseq) begin
        if (chk_on) compare_all();
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge bseq);
        end
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cfg_complete = 1'b0;
        cycles(3);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        cycles(3);
        chk_on = 1'b1;
        cycles(2);
        check1("R1 drive_low", done_drive_low, 1'b1);
        check1("R1 gts", gts, 1'b1);
        check1("R1 gsr", gsr, 1'b1);
        check1("R1 finished", finished, 1'b0);

        // R2: pin held low until complete, then sticky
        cur_req = "R2";
        rst = 1'b0;
        cycles(6);
        check1("R2 held low", done_drive_low, 1'b1);
        cfg_complete = 1'b1;
        cycles(1);
        cfg_complete = 1'b0;
        // R3: default sequence, stage n on edge n+2 of pin high
        cur_req = "R3";
        cycles(12);
        check1("R2 stays released", done_drive_low, 1'b0);
        check1("R6 finished end", finished, 1'b1);

        // R3: no pull-up, pin never reads high
        do_reset();
        opt_pullup = 1'b0;
        cycles(1);
        rst = 1'b0;
        cfg_complete = 1'b1;
        cycles(12);
        check1("R3 no pullup gts", gts, 1'b1);
        check1("R3 no pullup finished", finished, 1'b0);
        ext_pullup = 1'b1;
        cycles(10);
        check1("R3 ext pullup finished", finished, 1'b1);

        // R4 R5: other tap choices
        cur_req = "R4";
        do_reset();
        opt_pullup = 1'b1;
        ext_pullup = 1'b0;
        opt_io_tap = 2'd3;
        opt_rst_tap = 2'd0;
        cycles(1);
        rst = 1'b0;
        cfg_complete = 1'b1;
        cycles(12);
        cur_req = "R5";
        do_reset();
        opt_io_tap = 2'd2;
        opt_rst_tap = 2'd3;
        cycles(1);
        rst = 1'b0;
        cfg_complete = 1'b1;
        cycles(12);

        // R7: user clock source
        cur_req = "R7";
        rst = 1'b1;
        cfg_complete = 1'b0;
        cycles(2);
        clk_sel = 1'b1;
        opt_io_tap = 2'd0;
        opt_rst_tap = 2'd1;
        cycles(3);
        rst = 1'b0;
        cfg_complete = 1'b1;
        while (m_cnt < 3) @(negedge bseq);
        #1;
        // R8: stop the clock in its low phase
        cur_req = "R8";
        usr_run = 1'b0;
        #200;
        check1("R8 gts released", gts, 1'b0);
        check1("R8 gsr held", gsr, 1'b1);
        check1("R8 finished low", finished, 1'b0);
        check1("R8 pin released", done_drive_low, 1'b0);
        #300;
        check1("R8 gsr still held", gsr, 1'b1);
        check1("R8 finished still low", finished, 1'b0);
        usr_run = 1'b1;
        cur_req = "R7";
        cycles(8);
        check1("R7 finished on user clock", finished, 1'b1);

        // R9: user 3-state gating
        cur_req = "R9";
        gts_en = 1'b1; usr_gts = 1'b1; cycles(2);
        check1("R9 enabled active", gts, 1'b1);
        gts_inv = 1'b1; usr_gts = 1'b0; cycles(2);
        check1("R9 inverted active", gts, 1'b1);
        usr_gts = 1'b1; cycles(2);
        check1("R9 inverted idle", gts, 1'b0);
        gts_en = 1'b0; usr_gts = 1'b0; cycles(2);
        check1("R9 disabled ignored", gts, 1'b0);
        usr_gts = 1'b1; gts_inv = 1'b0; cycles(2);
        check1("R9 disabled ignored 2", gts, 1'b0);

        // R10: user set/reset gating
        cur_req = "R10";
        gsr_en = 1'b1; usr_gsr = 1'b1; cycles(2);
        check1("R10 enabled active", gsr, 1'b1);
        gsr_inv = 1'b1; usr_gsr = 1'b0; cycles(2);
        check1("R10 inverted active", gsr, 1'b1);
        usr_gsr = 1'b1; cycles(2);
        check1("R10 inverted idle", gsr, 1'b0);
        gsr_en = 1'b0; usr_gsr = 1'b0; cycles(2);
        check1("R10 disabled ignored", gsr, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule